// File: doc/BRIEF.md
# Hall Sensor Fault Monitor

This block supervises the three digital rotor-position lines of a six-step commutated brushless motor. It finds two kinds of fault. The first is a forbidden level pattern, where all three lines read alike. The second is a sequence fault, where two different lines change within a short window of each other. The Gray-coded position sequence lets only one line move at a time, so two lines moving close together is a fault. Each fault is held in its own sticky flag until the host raises the clear request. A cycle-count output changes level on every cycle in which any line changed, so the host can time rotation.

The raw lines pass through a two-flop synchroniser. A short warm-up state after reset lets that synchroniser fill before any checking starts. Each line then feeds an edge-stretch state machine that holds a fixed-length activity pulse after every rising or falling edge on that line. When the pulses of any two lines are active together, the sequence flag is set. The pulse length is a parameter and defaults to four clock cycles.

State machines: the warm-up machine has states `WU_FILL` and `WU_RUN`. It moves from `WU_FILL` to `WU_RUN` once the fill counter reaches the synchroniser depth, and it leaves `WU_RUN` only through reset. Each line's pulse machine has states `PL_IDLE` and `PL_HOLD`. An edge takes it from `PL_IDLE` to `PL_HOLD`. In `PL_HOLD` a new edge stays in `PL_HOLD` and restarts the count. When the count reaches the terminal value with no new edge, the machine returns to `PL_IDLE`. Each flag machine has states `FL_CLEAR` and `FL_SET`. A set condition takes it from `FL_CLEAR` to `FL_SET`. It goes back from `FL_SET` to `FL_CLEAR` only when the clear request is high and no set condition is present in the same cycle.

Top module: `hall_fault_monitor`

## Requirements
- R1: After reset both flags and the cycle-count output are 0. During the first three cycles after reset release the synchroniser is filling, and the monitor takes no fault and no edge from it, so a valid code held through reset produces nothing.
- R2: A code of 000 or 111 on the lines (hall_i[2], hall_i[1], hall_i[0]) sets the pattern flag, even when it lasts only one clock cycle, and the flag stays set afterwards.
- R3: The six valid codes are 100, 101, 001, 011, 010, 110, taken cyclically in either direction. Rotating through them with edges at least PULSE_LEN cycles apart sets neither flag.
- R4: Every edge on a line starts a pulse PULSE_LEN cycles long on that line. Edges on two different lines fewer than PULSE_LEN cycles apart set the sequence flag. Edges exactly PULSE_LEN or more cycles apart do not set it.
- R5: A single change of code that moves two lines in the same cycle sets the sequence flag.
- R6: An edge on a line whose pulse is still active restarts that pulse from its full length. Edges on the same line never set the sequence flag by themselves.
- R7: ccs_o inverts once for each clock cycle in which at least one line changed level. When two lines change in the same cycle it inverts once.
- R8: The flags are cleared only by clr_err_i being high at a clock edge. If a set condition is present in the same cycle, the flag stays set.
- R9: A level change on hall_i shows on ccs_o three rising clock edges after it is applied: two synchroniser stages and one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_i | input | 3 | Raw position lines; bit 2 is the first sensor, bit 0 the third |
| clr_err_i | input | 1 | Clear request for both fault flags |
| pat_err_o | output | 1 | Sticky forbidden-pattern flag |
| seq_err_o | output | 1 | Sticky sequence-fault flag |
| ccs_o | output | 1 | Cycle-count output; inverts on each cycle with a line change |

## Verification
The clear request and a fault can reach a flag in the same cycle. The bench provokes this by holding the forbidden code 000 so that the pattern condition is present every cycle, then raising the clear request for several cycles. The flag must read 1 throughout, and it must drop only after a valid code returns and a second clear is issued. A second collision is checked at the pulse level: two pulses meeting on the cycle a pulse ends. Edges exactly PULSE_LEN−1 and PULSE_LEN cycles apart are compared, and so is a restarted pulse that outlives its original window.

// File: rtl/hall_mon_pkg.sv
package hall_mon_pkg;

    localparam int unsigned HALL_LINES = 3;

    typedef enum logic {
        WU_FILL,
        WU_RUN
    } warm_state_e;

    typedef enum logic {
        PL_IDLE,
        PL_HOLD
    } pulse_state_e;

    typedef enum logic {
        FL_CLEAR,
        FL_SET
    } flag_state_e;

endpackage

// File: rtl/hall_sync.sv
module hall_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/hall_edge_pulse.sv
module hall_edge_pulse
    import hall_mon_pkg::*;
#(
    parameter int unsigned PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    output logic active_o
);

    localparam int unsigned CNT_W = (PULSE_LEN > 2) ? $clog2(PULSE_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PULSE_LEN - 1);

    pulse_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PL_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PL_IDLE: begin
                if (edge_i) begin
                    state_d = PL_HOLD;
                    cnt_d   = '0;
                end
            end
            PL_HOLD: begin
                if (edge_i) begin
                    cnt_d = '0;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = PL_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = PL_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        active_o = (state_q == PL_HOLD);
    end

endmodule

// File: rtl/hall_sticky_flag.sv
module hall_sticky_flag
    import hall_mon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FL_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_CLEAR: if (set_i) state_d = FL_SET;
            FL_SET:   if (clr_i && !set_i) state_d = FL_CLEAR;
            default:  state_d = FL_CLEAR;
        endcase
    end

    always_comb begin
        flag_o = (state_q == FL_SET);
    end

endmodule

// File: rtl/hall_fault_monitor.sv
module hall_fault_monitor
    import hall_mon_pkg::*;
#(
    parameter int unsigned PULSE_LEN   = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hall_i,
    input  logic       clr_err_i,
    output logic       pat_err_o,
    output logic       seq_err_o,
    output logic       ccs_o
);

    localparam int unsigned N      = HALL_LINES;
    localparam int unsigned WARM_W = $clog2(SYNC_STAGES + 1) + 1;
    localparam logic [WARM_W-1:0] WARM_LAST = WARM_W'(SYNC_STAGES);

    logic [N-1:0]      sync_w;
    logic [N-1:0]      prev_q;
    logic [N-1:0]      edge_vec;
    logic [N-1:0]      pulse_act;
    logic              pat_hit;
    logic              pair_overlap;
    logic              ccs_q;
    logic              run;

    warm_state_e       warm_q, warm_d;
    logic [WARM_W-1:0] warm_cnt_q, warm_cnt_d;

    hall_sync #(
        .WIDTH  (N),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (hall_i),
        .dout  (sync_w)
    );

    // warm-up state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm_q     <= WU_FILL;
            warm_cnt_q <= '0;
        end else begin
            warm_q     <= warm_d;
            warm_cnt_q <= warm_cnt_d;
        end
    end

    always_comb begin
        warm_d     = warm_q;
        warm_cnt_d = warm_cnt_q;
        unique case (warm_q)
            WU_FILL: begin
                if (warm_cnt_q == WARM_LAST) begin
                    warm_d = WU_RUN;
                end else begin
                    warm_cnt_d = warm_cnt_q + 1'b1;
                end
            end
            WU_RUN:  warm_d = WU_RUN;
            default: warm_d = WU_FILL;
        endcase
    end

    always_comb begin
        run = (warm_q == WU_RUN);
    end

    // previous synchronised levels and cycle-count output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            ccs_q  <= 1'b0;
        end else begin
            prev_q <= sync_w;
            ccs_q  <= ccs_q ^ (|edge_vec);
        end
    end

    assign edge_vec = run ? (sync_w ^ prev_q) : '0;
    assign pat_hit  = run && ((&sync_w) || !(|sync_w));

    for (genvar g = 0; g < N; g++) begin : g_line
        hall_edge_pulse #(
            .PULSE_LEN (PULSE_LEN)
        ) u_pulse (
            .clk      (clk),
            .rst_n    (rst_n),
            .edge_i   (edge_vec[g]),
            .active_o (pulse_act[g])
        );
    end

    always_comb begin
        pair_overlap = 1'b0;
        for (int a = 0; a < N; a++) begin
            for (int b = a + 1; b < N; b++) begin
                pair_overlap = pair_overlap | (pulse_act[a] & pulse_act[b]);
            end
        end
    end

    hall_sticky_flag u_pat_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (pat_hit),
        .clr_i  (clr_err_i),
        .flag_o (pat_err_o)
    );

    hall_sticky_flag u_seq_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (pair_overlap),
        .clr_i  (clr_err_i),
        .flag_o (seq_err_o)
    );

    assign ccs_o = ccs_q;

endmodule

// File: rtl/hall_fault_monitor_chk.sv
module hall_fault_monitor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       clr_err_i,
    input logic       pat_err_o,
    input logic       seq_err_o,
    input logic       ccs_o,
    input logic [2:0] edge_vec,
    input logic [2:0] pulse_act,
    input logic       pat_hit,
    input logic       pair_overlap
);

    assert_pat_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pat_hit |=> pat_err_o);

    assert_overlap_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pair_overlap |=> seq_err_o);

    assert_pat_only_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pat_err_o) |-> $past(clr_err_i));

    assert_seq_only_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seq_err_o) |-> $past(clr_err_i));

    assert_ccs_follows_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ccs_o != $past(ccs_o)) |-> $past(|edge_vec));

    for (genvar g = 0; g < 3; g++) begin : g_pl
        assert_pulse_from_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pulse_act[g]) |-> $past(edge_vec[g]));
    end

endmodule

bind hall_fault_monitor hall_fault_monitor_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_err_i    (clr_err_i),
    .pat_err_o    (pat_err_o),
    .seq_err_o    (seq_err_o),
    .ccs_o        (ccs_o),
    .edge_vec     (edge_vec),
    .pulse_act    (pulse_act),
    .pat_hit      (pat_hit),
    .pair_overlap (pair_overlap)
);

// File: tb/tb_hall_fault_monitor.sv
module tb_hall_fault_monitor;

    localparam int PL = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hall_i = 3'b100;
    logic       clr_err_i = 1'b0;
    logic       pat_err_o, seq_err_o, ccs_o;

    int  vectors = 0;
    int  fails = 0;
    int  cyc = 0;
    bit  done = 0;

    // reference model state
    int       last_edge [3];
    bit [2:0] m_code = 3'b100;
    bit       m_pat = 0, m_seq = 0, m_ccs = 0;
    int       pos = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hall_fault_monitor #(.PULSE_LEN(PL)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .hall_i    (hall_i),
        .clr_err_i (clr_err_i),
        .pat_err_o (pat_err_o),
        .seq_err_o (seq_err_o),
        .ccs_o     (ccs_o)
    );

    function automatic bit bad_code(bit [2:0] c);
        return (c == 3'b000) || (c == 3'b111);
    endfunction

    function automatic bit [2:0] seq_code(int k);
        int m = ((k % 6) + 6) % 6;
        case (m)
            0: return 3'b100;
            1: return 3'b101;
            2: return 3'b001;
            3: return 3'b011;
            4: return 3'b010;
            default: return 3'b110;
        endcase
    endfunction

    task automatic check(string req, string what, bit act, bit exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
        end
    endtask

    // apply a code at a negedge, update the model, then wait gap cycles
    task automatic drive(bit [2:0] code, int gap);
        bit [2:0] diff = code ^ m_code;
        if (|diff) m_ccs = ~m_ccs;
        if (bad_code(code)) m_pat = 1;
        for (int i = 0; i < 3; i++) begin
            if (diff[i]) begin
                for (int j = 0; j < 3; j++)
                    if (j != i && (cyc - last_edge[j]) < PL) m_seq = 1;
                last_edge[i] = cyc;
            end
        end
        m_code = code;
        hall_i = code;
        repeat (gap) @(negedge clk);
    endtask

    task automatic settle_check(string req);
        repeat (8) @(negedge clk);
        check(req, "pat_err_o", pat_err_o, m_pat);
        check(req, "seq_err_o", seq_err_o, m_seq);
        check(req, "ccs_o", ccs_o, m_ccs);
    endtask

    task automatic clear_flags();
        clr_err_i = 1'b1;
        @(negedge clk);
        clr_err_i = 1'b0;
        m_pat = bad_code(m_code);
        m_seq = 0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin : main
        bit old_ccs;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 3; i++) last_edge[i] = -1000;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values, valid code through warm-up yields nothing
        check("R1", "pat_err_o", pat_err_o, 1'b0);
        check("R1", "seq_err_o", seq_err_o, 1'b0);
        check("R1", "ccs_o", ccs_o, 1'b0);
        repeat (6) @(negedge clk);
        check("R1", "pat_err_o after warm-up", pat_err_o, 1'b0);
        check("R1", "ccs_o after warm-up", ccs_o, 1'b0);

        // R9: latency of three edges on ccs_o
        old_ccs = ccs_o;
        pos = 1;
        drive(seq_code(pos), 0);
        repeat (2) @(negedge clk);
        check("R9", "ccs_o two edges after", ccs_o, old_ccs);
        @(negedge clk);
        check("R9", "ccs_o three edges after", ccs_o, ~old_ccs);
        settle_check("R9");

        // R3: full rotation both ways, edges PL apart
        for (int k = 0; k < 6; k++) begin pos++; drive(seq_code(pos), PL); end
        for (int k = 0; k < 6; k++) begin pos--; drive(seq_code(pos), PL); end
        settle_check("R3");
        check("R3", "no pattern fault", pat_err_o, 1'b0);
        check("R3", "no sequence fault", seq_err_o, 1'b0);

        // R4: edges PL-1 apart on different lines
        drive(seq_code(pos + 1), PL - 1);
        drive(seq_code(pos + 2), 8);
        pos += 2;
        settle_check("R4");
        check("R4", "gap PL-1 sets flag", seq_err_o, 1'b1);
        clear_flags();
        settle_check("R8");
        check("R8", "seq cleared", seq_err_o, 1'b0);

        // R4: edges exactly PL apart
        drive(seq_code(pos + 1), PL);
        drive(seq_code(pos + 2), 8);
        pos += 2;
        settle_check("R4");
        check("R4", "gap PL no flag", seq_err_o, 1'b0);

        // R6: restart extends a pulse past its first window
        drive(seq_code(pos + 1), 3);
        drive(seq_code(pos), 3);
        drive(seq_code(pos - 1), 8);
        pos -= 1;
        settle_check("R6");
        check("R6", "restarted pulse overlaps", seq_err_o, 1'b1);
        clear_flags();
        // R6: same line toggled rapidly alone
        drive(seq_code(pos + 1), 1);
        drive(seq_code(pos), 1);
        drive(seq_code(pos + 1), 1);
        drive(seq_code(pos), 8);
        settle_check("R6");
        check("R6", "same line alone no flag", seq_err_o, 1'b0);

        // R5 and R7: two lines move in one cycle, ccs inverts once
        old_ccs = ccs_o;
        drive(seq_code(pos + 2), 8);
        pos += 2;
        settle_check("R5");
        check("R5", "double change sets flag", seq_err_o, 1'b1);
        check("R7", "ccs inverts once", ccs_o, ~old_ccs);
        clear_flags();

        // R2: one-cycle glitch to 111
        drive(3'b111, 1);
        drive(seq_code(pos), 8);
        settle_check("R2");
        check("R2", "glitch captured", pat_err_o, 1'b1);
        clear_flags();
        settle_check("R8");

        // R8: set and clear in the same cycle, set wins
        drive(3'b000, 4);
        clr_err_i = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R8", "pattern held under clear", pat_err_o, 1'b1);
        end
        clr_err_i = 1'b0;
        drive(seq_code(pos), 8);
        repeat (20) @(negedge clk);
        check("R8", "flag holds without clear", pat_err_o, 1'b1);
        clear_flags();
        settle_check("R8");
        check("R8", "pattern cleared", pat_err_o, 1'b0);

        // random walk segments
        for (int s = 0; s < 60; s++) begin
            for (int k = 0; k < 6; k++) begin
                int r = $urandom % 16;
                int gap = 1 + ($urandom % 7);
                if (r == 0) begin
                    drive(($urandom % 2) ? 3'b111 : 3'b000, gap);
                end else if (r == 1) begin
                    pos += 2;
                    drive(seq_code(pos), gap);
                end else if (r < 9) begin
                    pos++;
                    drive(seq_code(pos), gap);
                end else begin
                    pos--;
                    drive(seq_code(pos), gap);
                end
            end
            drive(seq_code(pos), 0);
            settle_check("R4");
            if ($urandom % 2) begin
                clear_flags();
                settle_check("R8");
            end
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule